// File: doc/BRIEF.md
# SDRAM Write Auto-Precharge Bank Guard

This block watches the command stream that a memory controller sends to a four-bank synchronous DRAM. It follows every bank through writes that carry auto-precharge and shows when each bank may be activated again. It decodes four commands from a 2-bit command code: NOP, ACTIVE, READ and WRITE. It also uses a 2-bit bank number and address bit 10. A single burst engine follows the write-with-auto-precharge burst that is in flight. Each bank has its own recovery countdown, which starts from the last data beat that was actually written.

Each bank runs through four named states. In `BK_IDLE` the bank may be activated. In `BK_OPEN` a row is open. In `BK_WBURST` a write-with-auto-precharge burst is in flight. In `BK_RECOV` the bank is precharging and counts down its recovery time. The bank transitions are:
- activate (IDLE to OPEN);
- auto-precharge write (OPEN to WBURST);
- burst complete or burst cut (WBURST to RECOV, or straight to IDLE when no cycles remain);
- recovery done (RECOV to IDLE).

The burst engine has two states, `BU_IDLE` and `BU_RUN`, with three transitions:
- start, on a legal write with auto-precharge;
- finish, on the final beat;
- cut, on a legal READ or WRITE to another bank.

A command that breaks the rules produces a one-cycle violation pulse and is otherwise ignored. Burst length and the recovery cycle count are static configuration inputs.

Top module: `sdram_wrap_guard`

## Requirements
- R1: A synchronous active-high reset sets every bank to idle: all `may_act_o` bits are 1, and `busy_o` and `viol_o` are 0.
- R2: An ACTIVE (command code 1) to an idle bank opens it. That bank's `may_act_o` bit is 0 from the following cycle onward, for as long as the bank is not idle.
- R3: A WRITE (command code 3) with `a10_i`=1 to an open bank starts a burst. Beat 0 is taken on the command edge. `busy_o` is high for BL-1 cycles after that edge, where BL is 2 when `cfg_bl4_i`=0 and 4 when `cfg_bl4_i`=1.
- R4: While a burst runs, any non-NOP command to the bursting bank raises `viol_o` in the next cycle. The command has no effect: the burst keeps its full length.
- R5: A legal READ (command code 2) or WRITE to a different, open bank during a burst ends the burst at once, and `busy_o` is 0 in the next cycle.
- R6: Let N be the value of `cfg_rec_i`, with 0 treated as 1. After a full burst, the bank's `may_act_o` bit rises in the cycle after the edge N-1 cycles past the final-beat edge. An ACTIVE is therefore first accepted N edges after the final beat.
- R7: After a cut burst, the last written beat is the one taken on the edge before the interrupting command. The N-edge recovery of R6 is measured from that beat.
- R8: An ACTIVE to a bank that is not idle raises `viol_o` in the next cycle and leaves the bank's state unchanged.
- R9: A WRITE with `a10_i`=0 to an open bank leaves the row open and starts no burst.
- R10: A READ or WRITE to a bank that is not open raises `viol_o` in the next cycle and is ignored, so it does not cut a running burst.
- R11: `viol_o` is a single-cycle pulse for each illegal command. It is 0 after a NOP or a legal command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 2 | Command code: 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE |
| bank_i | input | 2 | Bank number of the command |
| a10_i | input | 1 | Address bit 10; on a WRITE it selects auto-precharge |
| cfg_bl4_i | input | 1 | Burst length select: 0 gives 2 beats, 1 gives 4 beats |
| cfg_rec_i | input | 4 | Recovery cycle count N (0 acts as 1) |
| may_act_o | output | 4 | Per-bank flag: the bank is idle and may be activated |
| busy_o | output | 1 | A write-with-auto-precharge burst is in progress |
| viol_o | output | 1 | One-cycle pulse following an illegal command |

## Verification
A bank stuck in the wrong state shows up on `may_act_o`, either at once or within N cycles, when its countdown runs out at the wrong edge. It also shows up as a spurious or missing `viol_o` pulse on the next command to that bank. A burst counter that is off by one moves the falling edge of `busy_o` by a cycle. It also shifts the recovery window of that bank by the same amount, so the fault appears on two outputs. Comparing all outputs against a reference model on every clock catches these faults within a cycle of the point where they first become visible.

// File: rtl/sdram_apt_pkg.sv
`timescale 1ns/1ps
package sdram_apt_pkg;
    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_ACT = 2'd1,
        CMD_RD  = 2'd2,
        CMD_WR  = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE   = 2'd0,
        BK_OPEN   = 2'd1,
        BK_WBURST = 2'd2,
        BK_RECOV  = 2'd3
    } bank_st_e;

    typedef enum logic {
        BU_IDLE = 1'b0,
        BU_RUN  = 1'b1
    } burst_st_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
`timescale 1ns/1ps
module sdram_cmd_decode
    import sdram_apt_pkg::*;
#(
    parameter int NB   = 4,
    parameter int BA_W = $clog2(NB)
) (
    input  logic [1:0]      cmd_i,
    input  logic [BA_W-1:0] bank_i,
    output logic            is_nop_o,
    output logic            is_act_o,
    output logic            is_rd_o,
    output logic            is_wr_o,
    output logic [NB-1:0]   sel_o
);
    cmd_e code;

    always_comb begin
        code     = cmd_e'(cmd_i);
        is_nop_o = 1'b0;
        is_act_o = 1'b0;
        is_rd_o  = 1'b0;
        is_wr_o  = 1'b0;
        unique case (code)
            CMD_NOP: is_nop_o = 1'b1;
            CMD_ACT: is_act_o = 1'b1;
            CMD_RD:  is_rd_o  = 1'b1;
            CMD_WR:  is_wr_o  = 1'b1;
        endcase
    end

    for (genvar g = 0; g < NB; g++) begin : g_sel
        assign sel_o[g] = (bank_i == BA_W'(g));
    end
endmodule

// File: rtl/sdram_burst_fsm.sv
`timescale 1ns/1ps
module sdram_burst_fsm
    import sdram_apt_pkg::*;
#(
    parameter int NB     = 4,
    parameter int MAX_BL = 4,
    parameter int BA_W   = $clog2(NB)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [BA_W-1:0] start_bank_i,
    input  logic            cut_i,
    input  logic            bl4_i,
    output logic            busy_o,
    output logic [BA_W-1:0] bank_o,
    output logic            full_end_o
);
    localparam int LEFT_W = $clog2(MAX_BL);
    localparam logic [LEFT_W-1:0] LEFT_BL4 = LEFT_W'(MAX_BL - 1);
    localparam logic [LEFT_W-1:0] LEFT_BL2 = LEFT_W'(1);

    burst_st_e          st_q, st_d;
    logic [LEFT_W-1:0]  left_q, left_d;
    logic [BA_W-1:0]    bank_q, bank_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= BU_IDLE;
            left_q <= '0;
            bank_q <= '0;
        end else begin
            st_q   <= st_d;
            left_q <= left_d;
            bank_q <= bank_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        left_d = left_q;
        bank_d = bank_q;
        if (start_i) begin
            st_d   = BU_RUN;
            left_d = bl4_i ? LEFT_BL4 : LEFT_BL2;
            bank_d = start_bank_i;
        end else begin
            unique case (st_q)
                BU_IDLE: ;
                BU_RUN: begin
                    if (cut_i || left_q == LEFT_W'(1)) begin
                        st_d   = BU_IDLE;
                        left_d = '0;
                    end else begin
                        left_d = left_q - LEFT_W'(1);
                    end
                end
            endcase
        end
    end

    always_comb begin
        busy_o     = (st_q == BU_RUN);
        bank_o     = bank_q;
        full_end_o = (st_q == BU_RUN) && (left_q == LEFT_W'(1)) && !cut_i;
    end

    assert_cut_ends_burst_R5: assert property (@(posedge clk) disable iff (rst)
        (cut_i && !start_i) |=> !busy_o);
    assert_final_beat_ends_R3: assert property (@(posedge clk) disable iff (rst)
        (full_end_o && !start_i) |=> !busy_o);
endmodule

// File: rtl/sdram_bank_fsm.sv
`timescale 1ns/1ps
module sdram_bank_fsm
    import sdram_apt_pkg::*;
#(
    parameter int REC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_go_i,
    input  logic             wap_go_i,
    input  logic             end_full_i,
    input  logic             end_cut_i,
    input  logic [REC_W-1:0] rec_i,
    output bank_st_e         state_o,
    output logic             may_act_o
);
    bank_st_e         st_q, st_d;
    logic [REC_W-1:0] cnt_q, cnt_d;
    logic [REC_W-1:0] load_v;
    logic             load_zero;

    always_comb begin
        if (end_cut_i) begin
            load_zero = (rec_i <= REC_W'(2));
            load_v    = rec_i - REC_W'(2);
        end else begin
            load_zero = (rec_i <= REC_W'(1));
            load_v    = rec_i - REC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= BK_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            BK_IDLE:   if (act_go_i) st_d = BK_OPEN;
            BK_OPEN:   if (wap_go_i) st_d = BK_WBURST;
            BK_WBURST: begin
                if (end_full_i || end_cut_i) begin
                    if (load_zero) begin
                        st_d  = BK_IDLE;
                        cnt_d = '0;
                    end else begin
                        st_d  = BK_RECOV;
                        cnt_d = load_v;
                    end
                end
            end
            BK_RECOV: begin
                if (cnt_q == REC_W'(1)) begin
                    st_d  = BK_IDLE;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q - REC_W'(1);
                end
            end
        endcase
    end

    always_comb begin
        state_o   = st_q;
        may_act_o = (st_q == BK_IDLE);
    end

    assert_idle_exits_only_to_open_R2: assert property (@(posedge clk) disable iff (rst)
        (st_q == BK_IDLE) |=> (st_q == BK_IDLE || st_q == BK_OPEN));
    assert_recovery_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q == BK_RECOV && cnt_q > REC_W'(1)) |=> (st_q == BK_RECOV));
endmodule

// File: rtl/sdram_wrap_guard.sv
`timescale 1ns/1ps
module sdram_wrap_guard
    import sdram_apt_pkg::*;
#(
    parameter int NB     = 4,
    parameter int MAX_BL = 4,
    parameter int REC_W  = 4,
    parameter int BA_W   = $clog2(NB)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cmd_i,
    input  logic [BA_W-1:0]  bank_i,
    input  logic             a10_i,
    input  logic             cfg_bl4_i,
    input  logic [REC_W-1:0] cfg_rec_i,
    output logic [NB-1:0]    may_act_o,
    output logic             busy_o,
    output logic             viol_o
);
    logic            is_nop, is_act, is_rd, is_wr;
    logic [NB-1:0]   sel;
    bank_st_e        bank_st [NB];
    logic [NB-1:0]   wburst_vec;
    logic [BA_W-1:0] burst_bank;
    logic            full_end;
    logic            act_ok, rw_ok, wap_start, cut, bad;
    logic            viol_q;
    bank_st_e        tgt_st;

    sdram_cmd_decode #(.NB(NB)) i_dec (
        .cmd_i    (cmd_i),
        .bank_i   (bank_i),
        .is_nop_o (is_nop),
        .is_act_o (is_act),
        .is_rd_o  (is_rd),
        .is_wr_o  (is_wr),
        .sel_o    (sel)
    );

    always_comb begin
        tgt_st    = bank_st[bank_i];
        act_ok    = is_act && (tgt_st == BK_IDLE);
        rw_ok     = (is_rd || is_wr) && (tgt_st == BK_OPEN);
        wap_start = is_wr && a10_i && rw_ok;
        cut       = busy_o && rw_ok;
        bad       = !is_nop && !act_ok && !rw_ok;
    end

    sdram_burst_fsm #(.NB(NB), .MAX_BL(MAX_BL)) i_burst (
        .clk          (clk),
        .rst          (rst),
        .start_i      (wap_start),
        .start_bank_i (bank_i),
        .cut_i        (cut),
        .bl4_i        (cfg_bl4_i),
        .busy_o       (busy_o),
        .bank_o       (burst_bank),
        .full_end_o   (full_end)
    );

    for (genvar g = 0; g < NB; g++) begin : g_bank
        logic mine;
        assign mine = busy_o && (burst_bank == BA_W'(g));
        sdram_bank_fsm #(.REC_W(REC_W)) i_bank (
            .clk        (clk),
            .rst        (rst),
            .act_go_i   (sel[g] && act_ok),
            .wap_go_i   (sel[g] && wap_start),
            .end_full_i (mine && full_end),
            .end_cut_i  (mine && cut),
            .rec_i      (cfg_rec_i),
            .state_o    (bank_st[g]),
            .may_act_o  (may_act_o[g])
        );
        assign wburst_vec[g] = (bank_st[g] == BK_WBURST);
    end

    always_ff @(posedge clk) begin
        if (rst) viol_q <= 1'b0;
        else     viol_q <= bad;
    end
    assign viol_o = viol_q;

    assert_single_burst_bank_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wburst_vec) && ((wburst_vec != '0) == busy_o));
    assert_early_active_flagged_R8: assert property (@(posedge clk) disable iff (rst)
        (is_act && !may_act_o[bank_i]) |=> viol_o);
    assert_burst_bank_hit_flagged_R4: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !is_nop && bank_i == burst_bank) |=> viol_o);
    assert_idle_rw_flagged_R10: assert property (@(posedge clk) disable iff (rst)
        ((is_rd || is_wr) && may_act_o[bank_i]) |=> viol_o);
endmodule

// File: tb/test_sdram_wrap_guard.sv
`timescale 1ns/1ps
module test_sdram_wrap_guard;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cmd = 2'd0;
    logic [1:0] bank = 2'd0;
    logic       a10 = 1'b0;
    logic       bl4 = 1'b0;
    logic [3:0] rec = 4'd3;
    logic [3:0] may_act;
    logic       busy, viol;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sdram_wrap_guard i_sdram_wrap_guard (
        .clk(clk), .rst(rst), .cmd_i(cmd), .bank_i(bank), .a10_i(a10),
        .cfg_bl4_i(bl4), .cfg_rec_i(rec),
        .may_act_o(may_act), .busy_o(busy), .viol_o(viol)
    );

    // Reference model: 0 idle, 1 open, 2 bursting, 3 recovering
    int ms [4];
    int mc [4];
    int mbusy, mbank, mleft;
    bit mviol;

    function automatic void settle(int k, int v);
        if (v <= 0) begin ms[k] = 0; mc[k] = 0; end
        else begin ms[k] = 3; mc[k] = v; end
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) begin ms[i] = 0; mc[i] = 0; end
            mbusy = 0; mbank = 0; mleft = 0; mviol = 0;
        end else begin
            int c, b, n;
            bit act_ok, rw_ok;
            c = int'(cmd); b = int'(bank);
            n = (rec == 0) ? 1 : int'(rec);
            act_ok = (c == 1) && (ms[b] == 0);
            rw_ok  = (c == 2 || c == 3) && (ms[b] == 1);
            for (int i = 0; i < 4; i++)
                if (ms[i] == 3) begin
                    if (mc[i] == 1) begin ms[i] = 0; mc[i] = 0; end
                    else mc[i] = mc[i] - 1;
                end
            if (mbusy != 0) begin
                if (rw_ok) begin settle(mbank, n - 2); mbusy = 0; end
                else if (mleft == 1) begin settle(mbank, n - 1); mbusy = 0; end
                else mleft = mleft - 1;
            end
            if (act_ok) ms[b] = 1;
            if (rw_ok && c == 3 && a10) begin
                ms[b] = 2; mbusy = 1; mbank = b; mleft = bl4 ? 3 : 1;
            end
            mviol = (c != 0) && !act_ok && !rw_ok;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < 4; i++)
                chk("R2 model may_act", int'(may_act[i]), (ms[i] == 0) ? 1 : 0);
            chk("R3 model busy", int'(busy), mbusy);
            chk("R11 model viol", int'(viol), int'(mviol));
        end
    end

    // drive at a negedge, return at the negedge after the accepting edge
    task automatic issue(int c, int b, bit a);
        cmd = 2'(c); bank = 2'(b); a10 = a;
        @(negedge clk);
        cmd = 2'd0; bank = 2'd0; a10 = 1'b0;
    endtask

    task automatic do_reset(bit l4, int r);
        @(negedge clk);
        rst = 1'b1; bl4 = l4; rec = 4'(r);
        cmd = 2'd0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset(1'b0, 3);
        chk("R1 may_act", int'(may_act), 15);
        chk("R1 busy", int'(busy), 0);
        chk("R1 viol", int'(viol), 0);

        // A: BL2, N=3 full burst
        issue(1, 0, 0);
        chk("R2 opened bank flag", int'(may_act[0]), 0);
        issue(3, 0, 1);
        chk("R3 busy after write", int'(busy), 1);
        issue(0, 0, 0);
        chk("R3 busy ends BL2", int'(busy), 0);
        chk("R6 recovering 1", int'(may_act[0]), 0);
        issue(0, 0, 0);
        chk("R6 recovering 2", int'(may_act[0]), 0);
        issue(0, 0, 0);
        chk("R6 idle after N", int'(may_act[0]), 1);
        issue(1, 0, 0);
        chk("R6 active accepted", int'(viol), 0);

        // B: early ACTIVE
        do_reset(1'b0, 3);
        issue(1, 1, 0);
        issue(3, 1, 1);
        issue(0, 0, 0);
        issue(1, 1, 0);
        chk("R8 early active viol", int'(viol), 1);
        issue(0, 0, 0);
        chk("R11 pulse one cycle", int'(viol), 0);
        chk("R8 state unchanged idle", int'(may_act[1]), 1);

        // C: BL4, N=4, cut by plain write to another bank
        do_reset(1'b1, 4);
        issue(1, 2, 0);
        issue(1, 3, 0);
        issue(3, 2, 1);
        issue(0, 0, 0);
        chk("R3 busy mid BL4", int'(busy), 1);
        issue(3, 3, 0);
        chk("R5 cut ends busy", int'(busy), 0);
        chk("R9 plain write row open", int'(may_act[3]), 0);
        chk("R7 recovering 1", int'(may_act[2]), 0);
        issue(0, 0, 0);
        chk("R7 recovering 2", int'(may_act[2]), 0);
        chk("R9 no burst", int'(busy), 0);
        issue(0, 0, 0);
        chk("R7 idle after cut", int'(may_act[2]), 1);

        // D: command to bursting bank is ignored
        do_reset(1'b1, 2);
        issue(1, 0, 0);
        issue(3, 0, 1);
        issue(2, 0, 0);
        chk("R4 same bank viol", int'(viol), 1);
        chk("R4 burst continues", int'(busy), 1);
        issue(0, 0, 0);
        chk("R4 still busy", int'(busy), 1);
        issue(0, 0, 0);
        chk("R4 full length end", int'(busy), 0);

        // E: read to idle bank
        do_reset(1'b0, 1);
        issue(2, 1, 0);
        chk("R10 read idle viol", int'(viol), 1);
        chk("R10 ignored", int'(may_act[1]), 1);

        // random phases, compared each cycle by the model
        for (int p = 0; p < 4; p++) begin
            do_reset(p[0], (p == 3) ? 0 : 2 + p * 2);
            for (int k = 0; k < 600; k++) begin
                issue(int'($urandom % 4), int'($urandom % 4), 1'($urandom % 2));
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule